// File: doc/BRIEF.md
# DMA Bus Request Pacer

This block sits beside a single-channel DMA engine and decides, clock by clock, whether that engine may request the system bus. The engine's control logic sets a run bit, chooses one of three pacing modes and loads a transfer count. The block then raises a bus request, or holds it low, according to that mode. The engine reports each completed transfer with a strobe, and the block counts down the remaining transfers.

Two modes generate requests internally. Full-rate mode asks for the bus on every cycle until the count is used up. Capped mode limits the engine to a programmed share of bus time. It measures that share over back-to-back 1024-clock windows and lets the engine hold the bus only during the leading clocks of each window. Clocks that another master takes inside that leading part are simply lost. In device-paced mode, an external request line decides when the engine asks for the bus.

A pending unmasked interrupt can make the engine step aside in every mode, if yielding is enabled. When the count runs out, the block drops the request, clears the run bit and raises a one-cycle completion pulse.

Top module: `dma_req_pacer`

## Requirements
- R1: After reset, bus_req_o, done_o and cnt_o are all 0, and the run bit is clear.
- R2: While the run bit is clear, bus_req_o stays 0 in every mode. The run bit is set by run_set_i and cleared by run_clr_i; the clear wins if both are high.
- R3: In full-rate mode (mode_i = 2'b00), bus_req_o is 1 on every cycle in which the run bit is set and cnt_o is nonzero.
- R4: In capped mode (mode_i = 2'b01), bus_req_o may be 1 only while the window position is below a limit N. The share_i field selects N: 2'b00 gives 128, 2'b01 gives 256, 2'b10 gives 512 and 2'b11 gives 768.
- R5: The window position is 0 in the first cycle in which the run bit is set. It then advances by one every clock and wraps after 1024. Allotment lost inside one window does not extend the next window, which again allows exactly N clocks.
- R6: In device-paced mode (mode_i = 2'b10), bus_req_o follows dev_req_i in the same cycle while the run bit is set and cnt_o is nonzero.
- R7: While irq_pend_i and irq_yield_i are both 1, bus_req_o is 0 in every mode. When irq_yield_i is 0, irq_pend_i has no effect.
- R8: cnt_load_i loads cnt_o from cnt_val_i at the next edge. Each accepted done strobe lowers cnt_o by one at the next edge. Without a load or an accepted strobe, cnt_o holds its value.
- R9: The strobe that brings cnt_o to 0 causes three things at the next edge: done_o is 1 for exactly one cycle, the run bit clears, and bus_req_o is 0.
- R10: When run_clr_i is applied during a transfer, bus_req_o is 0 from the next cycle. cnt_o keeps its value and done_o stays 0.
- R11: Mode 2'b11 is reserved. In that mode bus_req_o stays 0.
- R12: A xfer_done_i strobe counts only while bus_gnt_i is 1 and the run bit is set. Otherwise cnt_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_set_i | input | 1 | Set the run bit |
| run_clr_i | input | 1 | Clear the run bit |
| mode_i | input | 2 | Pacing mode |
| share_i | input | 2 | Bus-time share for capped mode |
| cnt_load_i | input | 1 | Load the transfer count |
| cnt_val_i | input | CNT_W | Value to load |
| dev_req_i | input | 1 | External device request |
| bus_gnt_i | input | 1 | Bus granted to this engine |
| irq_pend_i | input | 1 | Unmasked interrupt pending |
| irq_yield_i | input | 1 | Enable yielding to interrupts |
| xfer_done_i | input | 1 | One transfer finished |
| bus_req_o | output | 1 | Bus request |
| cnt_o | output | CNT_W | Remaining transfers |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle. The first is the interrupt yield, which cuts into the capped allotment. The second is the window rollover, which must restore a full allotment with no carry-over. The bench holds an interrupt over the first 100 clocks of a capped run. It then compares the request against a model over two full windows: the second window must show exactly N requesting clocks. A second collision is the final done strobe landing in the same cycle as the request. The bench judges it by the done pulse, the zero count and the dropped request on the following cycle.

// File: rtl/dma_rg_pkg.sv
package dma_rg_pkg;
  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_CAP  = 2'b01,
    MODE_DEV  = 2'b10,
    MODE_RSV  = 2'b11
  } pace_mode_e;

  // share code -> allotment in eighths of a window
  function automatic int unsigned share_eighths(input logic [1:0] share);
    case (share)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/rg_window.sv
module rg_window #(
  parameter int unsigned WIN_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] share_i,
  output logic       open_o
);
  import dma_rg_pkg::*;

  localparam int unsigned SHIFT = WIN_W - 3;

  logic [WIN_W-1:0] pos_q;
  logic [WIN_W:0]   limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (!run_i) pos_q <= '0;
    else             pos_q <= pos_q + 1'b1;
  end

  assign limit  = (WIN_W+1)'(share_eighths(share_i)) << SHIFT;
  assign open_o = {1'b0, pos_q} < limit;

  // R5
  win_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> pos_q == '0);
endmodule

// File: rtl/rg_count.sv
module rg_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = dec_i && !load_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= last_o;
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !dec_i) |=> $stable(cnt_o));
  // R9
  done_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_o == '0);
endmodule

// File: rtl/dma_req_pacer.sv
module dma_req_pacer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned WIN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_set_i,
  input  logic             run_clr_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       share_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             dev_req_i,
  input  logic             bus_gnt_i,
  input  logic             irq_pend_i,
  input  logic             irq_yield_i,
  input  logic             xfer_done_i,
  output logic             bus_req_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  import dma_rg_pkg::*;

  logic run_q, win_open, cnt_nz, yield, mode_ok, dec, last;
  pace_mode_e mode;

  assign mode = pace_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= 1'b0;
    else if (last || run_clr_i)  run_q <= 1'b0;
    else if (run_set_i)          run_q <= 1'b1;
  end

  rg_window #(.WIN_W(WIN_W)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .share_i (share_i),
    .open_o  (win_open)
  );

  assign cnt_nz = |cnt_o;
  assign dec    = xfer_done_i && bus_gnt_i && run_q && cnt_nz;

  rg_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load_i),
    .load_val_i (cnt_val_i),
    .dec_i      (dec),
    .cnt_o      (cnt_o),
    .last_o     (last),
    .done_o     (done_o)
  );

  always_comb begin
    case (mode)
      MODE_FULL: mode_ok = 1'b1;
      MODE_CAP:  mode_ok = win_open;
      MODE_DEV:  mode_ok = dev_req_i;
      default:   mode_ok = 1'b0;
    endcase
  end

  assign yield     = irq_pend_i && irq_yield_i;
  assign bus_req_o = run_q && cnt_nz && !yield && mode_ok;

  // R7
  irq_yield_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pend_i && irq_yield_i) |-> !bus_req_o);
  // R10
  clr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_clr_i |=> !bus_req_o);
  // R10
  clr_keep_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_clr_i && !cnt_load_i && !xfer_done_i) |=> $stable(cnt_o));
  // R11
  rsv_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> !bus_req_o);
  // R4
  cap_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && !win_open) |-> !bus_req_o);
  // R9
  done_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o);
endmodule

// File: tb/tb_dma_req_pacer.sv
module tb_dma_req_pacer;
  localparam int unsigned CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run_set = 0, run_clr = 0, cnt_load = 0, dev_req = 0, gnt = 0;
  logic irq_pend = 0, irq_yield = 0, xdone = 0;
  logic [1:0] mode = 2'b00, share = 2'b00;
  logic [CNT_W-1:0] cnt_val = '0;
  logic bus_req, done;
  logic [CNT_W-1:0] cnt;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_req_pacer #(.CNT_W(CNT_W), .WIN_W(10)) dut (
    .clk_i(clk), .rst_ni(rst_n), .run_set_i(run_set), .run_clr_i(run_clr),
    .mode_i(mode), .share_i(share), .cnt_load_i(cnt_load), .cnt_val_i(cnt_val),
    .dev_req_i(dev_req), .bus_gnt_i(gnt), .irq_pend_i(irq_pend),
    .irq_yield_i(irq_yield), .xfer_done_i(xdone),
    .bus_req_o(bus_req), .cnt_o(cnt), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {mode[1:0], share[1:0], dev, irq, yield_en, exp_req}
  localparam logic [7:0] VEC [8] = '{
    8'b00_00_0_0_0_1,  // R3 full rate
    8'b00_00_0_1_1_0,  // R7 yield
    8'b00_00_0_1_0_1,  // R7 pending ignored without enable
    8'b10_00_1_0_0_1,  // R6 device asserted
    8'b10_00_0_0_0_0,  // R6 device idle
    8'b10_00_1_1_1_0,  // R7 yield in device mode
    8'b01_00_0_0_0_1,  // R4 capped, inside allotment
    8'b11_00_1_0_0_0   // R11 reserved
  };

  task automatic pulse_run(input bit set);
    @(negedge clk);
    if (set) run_set = 1; else run_clr = 1;
    @(negedge clk);
    run_set = 0; run_clr = 0;
  endtask

  task automatic load(input int v);
    @(negedge clk);
    cnt_load = 1; cnt_val = CNT_W'(v);
    @(negedge clk);
    cnt_load = 0;
  endtask

  task automatic strobe(input bit g);
    @(negedge clk);
    xdone = 1; gnt = g;
    @(negedge clk);
    xdone = 0; gnt = 0;
  endtask

  task automatic cap_run(input logic [1:0] sh, input int len, input bit irq_head);
    int lim, bad, bad_k, hits2;
    lim = (sh == 2'b00) ? 128 : (sh == 2'b01) ? 256 : (sh == 2'b10) ? 512 : 768;
    bad = 0; bad_k = -1; hits2 = 0;
    pulse_run(0);
    load(16'hFFFF);
    mode = 2'b01; share = sh; irq_yield = 1;
    pulse_run(1);
    for (int k = 0; k < len; k++) begin
      bit exp;
      irq_pend = irq_head && (k < 100);
      #1;
      exp = ((k % 1024) < lim) && !(irq_head && k < 100);
      if (bus_req !== exp) begin bad++; if (bad_k < 0) bad_k = k; end
      if (k >= 1024 && bus_req) hits2++;
      @(negedge clk);
    end
    irq_pend = 0; irq_yield = 0;
    check(bad == 0, "R4 capped request pattern", bad_k, -1);
    if (len > 1024) check(hits2 == lim, "R5 next window full allotment", hits2, lim);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(bus_req == 0 && done == 0 && cnt == 0, "R1 reset outputs", int'(cnt), 0);
    rst_n = 1;
    @(negedge clk);

    load(100);
    mode = 2'b00;
    #1;
    check(bus_req == 0, "R2 no request before run", bus_req, 0);
    check(cnt == 100, "R8 load", int'(cnt), 100);

    pulse_run(1);
    foreach (VEC[i]) begin
      {mode, share, dev_req, irq_pend, irq_yield} = VEC[i][7:1];
      #1;
      check(bus_req == VEC[i][0], $sformatf("vector %0d (R3/R4/R6/R7/R11)", i),
            bus_req, VEC[i][0]);
      @(negedge clk);
    end
    dev_req = 0; irq_pend = 0; irq_yield = 0; mode = 2'b00;

    // R5 / R7 / R4: yield eats the head of window 0, window 1 is full
    cap_run(2'b00, 2048, 1'b1);
    cap_run(2'b01, 1024, 1'b0);
    cap_run(2'b10, 1024, 1'b0);
    cap_run(2'b11, 2048, 1'b0);

    // count down and completion
    pulse_run(0);
    mode = 2'b00;
    load(3);
    pulse_run(1);
    strobe(1);
    #1; check(cnt == 2, "R8 decrement", int'(cnt), 2);
    strobe(0);
    #1; check(cnt == 2, "R12 strobe without grant ignored", int'(cnt), 2);
    strobe(1);
    #1; check(done == 0 && bus_req == 1, "R3 still requesting", bus_req, 1);
    strobe(1);
    #1; check(done == 1, "R9 done pulse", done, 1);
    check(cnt == 0 && bus_req == 0, "R9 request dropped at zero", bus_req, 0);
    @(negedge clk); #1;
    check(done == 0, "R9 single-cycle pulse", done, 0);
    load(4);
    #1; check(bus_req == 0, "R9 run bit cleared", bus_req, 0);

    // mid-transfer clear
    pulse_run(1);
    #1; check(bus_req == 1, "R3 restart", bus_req, 1);
    strobe(1);
    pulse_run(0);
    #1; check(bus_req == 0 && cnt == 3 && done == 0, "R10 clear keeps count", int'(cnt), 3);
    strobe(1);
    #1; check(cnt == 3, "R12 strobe while stopped ignored", int'(cnt), 3);
    @(negedge clk); #1;
    check(done == 0, "R10 no completion", done, 0);

    // R2: clear wins over set
    @(negedge clk); run_set = 1; run_clr = 1;
    @(negedge clk); run_set = 0; run_clr = 0;
    #1; check(bus_req == 0, "R2 clear wins", bus_req, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule